// File: doc/BRIEF.md
# I2C Wiper-Control Slave

This block is the serial control front end of a four-channel digital potentiometer. It listens on a two-wire bus (SCL, SDA), recognises bus start and stop events, and answers to a 7-bit device address. The upper five bits of that address are fixed and the lower two come from strap pins. A write transaction carries an instruction byte and then a data byte. The instruction byte picks one of four wiper channels. It can also force that channel to mid-scale, put that one channel into shutdown or bring it out, and set two general-purpose logic outputs.

The block holds one 8-bit wiper code for each channel. It shows each channel's effective shutdown state, which merges the per-channel flag with an active-low global shutdown pin. Both shutdown mechanisms leave the stored codes unchanged, so a channel returns to its previous setting when shutdown is released. SCL and SDA are sampled through synchronisers on the system clock. The slave acknowledges by asserting an open-drain enable that pulls SDA low.

Top module: `dpot_i2c_slave`

## Requirements
- R1: A bus start is SDA falling while SCL is high, and a bus stop is SDA rising while SCL is high. Data bits are sampled on SCL rising, MSB first.
- R2: The first byte after a start holds the address in bits [7:1] and R/W in bit [0]. The block matches the address against {5'b01011, addr_pins[1], addr_pins[0]}. With any other address the block never asserts sda_oe before the next start.
- R3: A matched write is acknowledged on the ninth SCL clock of the address byte, the instruction byte and the data byte. sda_oe is asserted during that clock's high phase.
- R4: The instruction byte layout is as follows. Bits [6:5] select the channel. Bit [4] is the mid-scale command and bit [3] is the shutdown flag. Bit [2] drives gpo[1] and bit [1] drives gpo[0]. Bits [7] and [0] have no effect.
- R5: With bit [4]=0, the data byte is stored as the selected channel's code, which appears on wiper_code[8*ch+7:8*ch].
- R6: With bit [4]=1, the selected code becomes 8'h80 when the instruction byte ends. The data byte that follows is acknowledged and discarded.
- R7: Bit [3] sets or clears the shutdown flag of the selected channel only. The flag drives chan_off[ch] and leaves that channel's code unchanged.
- R8: While shdn_n is low, all chan_off bits are 1 and all codes are unchanged. When shdn_n returns high, each chan_off bit follows its own flag again.
- R9: After reset every code is 8'h80, every shutdown flag is 0, gpo is 0 and sda_oe is 0.
- R10: A stop or repeated start in the middle of a byte abandons the transaction. A partly received byte has no effect.
- R11: A matched address with R/W=1 is acknowledged. After that the block does not drive SDA until the next start.
- R12: Bytes after the data byte of a write are not acknowledged and do not change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen on the pad |
| sda_in | input | 1 | Bus data line as seen on the pad |
| addr_pins | input | 2 | Strap pins giving the two low address bits |
| shdn_n | input | 1 | Active-low shutdown of all channels |
| sda_oe | output | 1 | When 1, the pad pulls SDA low (acknowledge) |
| wiper_code | output | 32 | Four 8-bit wiper codes, channel 0 in the low byte |
| chan_off | output | 4 | Effective shutdown state for each channel |
| gpo | output | 2 | General-purpose logic outputs |

## Verification
Two events can land on the same system clock edge. One is a change of the global shutdown pin. The other is the instruction byte ending and writing a channel's own shutdown flag. The bench provokes this by toggling shdn_n at a random point inside each random write transaction, so the toggle sometimes falls on the edge where the instruction byte is applied. After the stop, it judges chan_off against the OR of the modelled per-channel flags and the inverted pin, and it checks that every wiper code is unchanged by the pin. An assertion also requires all channels to be off in any cycle where the pin is low.

// File: rtl/dpot_pkg.sv
// Shared constants and types for the wiper-control slave.
// Assumes a byte-wide bus and a 2-bit channel select field in the instruction byte.
package dpot_pkg;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 2;
    localparam int NCH    = 1 << SEL_W;
    localparam int CNT_W  = 4;
    localparam logic [4:0] DEV_PREFIX = 5'b01011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_INSTR,
        ST_DATA,
        ST_SKIP
    } xfer_st_t;
endpackage

// File: rtl/dpot_line_sync.sv
// Synchronises the raw SCL/SDA pads into the clock domain and detects
// SCL edges plus bus start and stop events.
// Assumes the bus is much slower than clk, so each level lasts several cycles.
module dpot_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;

    // Metastability chain and one-cycle history; idle bus level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    // Edge and bus-condition decode from the current and previous samples.
    always_comb begin
        scl_s     = scl_sh[STAGES-1];
        sda_s     = sda_sh[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/dpot_byte_engine.sv
// Bit counter, shift register and transaction state machine. Emits one-cycle
// pulses when a complete instruction byte or data byte has arrived, and drives
// the acknowledge enable through the ninth clock.
// Assumes the synchronised edges and conditions come from dpot_line_sync.
module dpot_byte_engine
    import dpot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic [1:0]        addr_pins,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              instr_valid,
    output logic              data_valid,
    output logic [CNT_W-1:0]  bit_cnt
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

    xfer_st_t          state;
    xfer_st_t          next_q;
    xfer_st_t          next_c;
    logic [BYTE_W-2:0] shreg;
    logic [BYTE_W-1:0] byte_c;
    logic              ack_q;
    logic              ack_c;
    logic              in_ack;
    logic [6:0]        own_addr;

    // Decide acknowledge and follow-on state for the byte completing now.
    always_comb begin
        own_addr = {DEV_PREFIX, addr_pins};
        byte_c   = {shreg, sda_s};
        ack_c    = 1'b0;
        next_c   = ST_SKIP;
        unique case (state)
            ST_ADDR: begin
                ack_c  = (byte_c[7:1] == own_addr);
                next_c = (ack_c && !byte_c[0]) ? ST_INSTR : ST_SKIP;
            end
            ST_INSTR: begin
                ack_c  = 1'b1;
                next_c = ST_DATA;
            end
            ST_DATA: begin
                ack_c  = 1'b1;
                next_c = ST_SKIP;
            end
            default: begin
                ack_c  = 1'b0;
                next_c = ST_SKIP;
            end
        endcase
    end

    // Transaction sequencing: bit capture, acknowledge slot and byte hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            next_q      <= ST_IDLE;
            shreg       <= '0;
            bit_cnt     <= '0;
            ack_q       <= 1'b0;
            in_ack      <= 1'b0;
            sda_oe      <= 1'b0;
            rx_byte     <= '0;
            instr_valid <= 1'b0;
            data_valid  <= 1'b0;
        end else begin
            instr_valid <= 1'b0;
            data_valid  <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (scl_rise && bit_cnt < ACK_SLOT) begin
                    shreg   <= byte_c[BYTE_W-2:0];
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        rx_byte     <= byte_c;
                        ack_q       <= ack_c;
                        next_q      <= next_c;
                        instr_valid <= (state == ST_INSTR);
                        data_valid  <= (state == ST_DATA);
                    end
                end
                if (scl_fall) begin
                    if (in_ack) begin
                        in_ack  <= 1'b0;
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                        state   <= next_q;
                    end else if (bit_cnt == ACK_SLOT) begin
                        in_ack <= 1'b1;
                        sda_oe <= ack_q;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dpot_chan_bank.sv
// Per-channel wiper codes and shutdown flags, the shared command latch and
// the logic outputs. Applies instruction and data pulses from the byte engine.
// Assumes instr_valid and data_valid are single-cycle and mutually exclusive.
module dpot_chan_bank
    import dpot_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  instr_valid,
    input  logic                  data_valid,
    input  logic [BYTE_W-1:0]     rx_byte,
    input  logic                  shdn_n,
    output logic [NCH*BYTE_W-1:0] wiper_code,
    output logic [NCH-1:0]        chan_off,
    output logic [1:0]            gpo
);
    localparam logic [BYTE_W-1:0] MIDSCALE = BYTE_W'(1) << (BYTE_W - 1);

    logic [SEL_W-1:0] sel_q;
    logic             mid_q;

    // Latch the channel select and mid-scale flag and the logic outputs from the instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            mid_q <= 1'b0;
            gpo   <= 2'b00;
        end else if (instr_valid) begin
            sel_q <= rx_byte[6:5];
            mid_q <= rx_byte[4];
            gpo   <= {rx_byte[2], rx_byte[1]};
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [BYTE_W-1:0] code_q;
        logic              sd_q;

        // Channel state: mid-scale overwrite, data load, and shutdown flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q <= MIDSCALE;
                sd_q   <= 1'b0;
            end else if (instr_valid && rx_byte[6:5] == SEL_W'(c)) begin
                sd_q <= rx_byte[3];
                if (rx_byte[4]) begin
                    code_q <= MIDSCALE;
                end
            end else if (data_valid && sel_q == SEL_W'(c) && !mid_q) begin
                code_q <= rx_byte;
            end
        end

        // Outputs: stored code, and shutdown merged with the global pin.
        always_comb begin
            wiper_code[c*BYTE_W +: BYTE_W] = code_q;
            chan_off[c]                    = sd_q | ~shdn_n;
        end
    end
endmodule

// File: rtl/dpot_i2c_slave.sv
// Top of the wiper-control slave: line synchroniser, byte engine and channel bank.
// Assumes an external open-drain pad that pulls SDA low while sda_oe is 1.
module dpot_i2c_slave
    import dpot_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    input  logic [1:0]            addr_pins,
    input  logic                  shdn_n,
    output logic                  sda_oe,
    output logic [NCH*BYTE_W-1:0] wiper_code,
    output logic [NCH-1:0]        chan_off,
    output logic [1:0]            gpo
);
    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [BYTE_W-1:0] rx_byte;
    logic              instr_valid;
    logic              data_valid;
    logic [CNT_W-1:0]  bit_cnt;

    dpot_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    dpot_byte_engine u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .sda_s       (sda_s),
        .addr_pins   (addr_pins),
        .sda_oe      (sda_oe),
        .rx_byte     (rx_byte),
        .instr_valid (instr_valid),
        .data_valid  (data_valid),
        .bit_cnt     (bit_cnt)
    );

    dpot_chan_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .data_valid  (data_valid),
        .rx_byte     (rx_byte),
        .shdn_n      (shdn_n),
        .wiper_code  (wiper_code),
        .chan_off    (chan_off),
        .gpo         (gpo)
    );
endmodule

// File: rtl/dpot_i2c_slave_chk.sv
// Property checker for the wiper-control slave, bound into the top module.
// Observes ports and the signals passed between the submodules.
module dpot_i2c_slave_chk
    import dpot_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_s,
    input logic                  stop_det,
    input logic                  start_det,
    input logic [CNT_W-1:0]      bit_cnt,
    input logic                  instr_valid,
    input logic                  data_valid,
    input logic [BYTE_W-1:0]     rx_byte,
    input logic                  shdn_n,
    input logic                  sda_oe,
    input logic [NCH*BYTE_W-1:0] wiper_code,
    input logic [NCH-1:0]        chan_off
);
    AST_ACK_IN_NINTH_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> (bit_cnt == CNT_W'(BYTE_W) && !scl_s)); // R3

    AST_STOP_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det || start_det) |=> !sda_oe); // R10

    AST_CODES_HOLD_WITHOUT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && !data_valid) |=> $stable(wiper_code)); // R7

    AST_SD_ONLY_INSTR_KEEPS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !rx_byte[4]) |=> $stable(wiper_code)); // R4

    AST_GLOBAL_SHDN_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |-> (chan_off == '1)); // R8
endmodule

bind dpot_i2c_slave dpot_i2c_slave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .stop_det    (stop_det),
    .start_det   (start_det),
    .bit_cnt     (bit_cnt),
    .instr_valid (instr_valid),
    .data_valid  (data_valid),
    .rx_byte     (rx_byte),
    .shdn_n      (shdn_n),
    .sda_oe      (sda_oe),
    .wiper_code  (wiper_code),
    .chan_off    (chan_off)
);

// File: tb/dpot_i2c_slave_test.sv
// Self-checking bench: directed corner cases plus seeded random write traffic.
module dpot_i2c_slave_test;
    localparam int H = 8;
    localparam logic [1:0] PINS = 2'b10;
    localparam logic [6:0] OWN  = {5'b01011, PINS};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        shdn_n = 1'b1;
    logic        sda_oe;
    logic [31:0] wiper_code;
    logic [3:0]  chan_off;
    logic [1:0]  gpo;
    logic        sda_bus;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_code [4];
    logic [3:0] exp_sd;
    logic [1:0] exp_gpo;

    assign sda_bus = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    dpot_i2c_slave uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_m),
        .sda_in     (sda_bus),
        .addr_pins  (PINS),
        .shdn_n     (shdn_n),
        .sda_oe     (sda_oe),
        .wiper_code (wiper_code),
        .chan_off   (chan_off),
        .gpo        (gpo)
    );

    function automatic logic [31:0] pack_codes();
        return {exp_code[3], exp_code[2], exp_code[1], exp_code[0]};
    endfunction

    function automatic logic [3:0] exp_off(input logic [3:0] sd, input logic pin_n);
        return sd | {4{~pin_n}};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk({req, " codes"}, wiper_code, pack_codes());
        chk({req, " chan_off"}, {28'd0, chan_off}, {28'd0, exp_off(exp_sd, shdn_n)});
        chk({req, " gpo"}, {30'd0, gpo}, {30'd0, exp_gpo});
    endtask

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        sda_m = 1'b0; half();
        scl_m = 1'b0; half();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; half();
        scl_m = 1'b1; half();
        sda_m = 1'b1; half();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = b[7-i]; half();
            scl_m = 1'b1;   half();
            scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; half();
        scl_m = 1'b1;
        repeat (H/2) @(negedge clk);
        ack = (sda_bus == 1'b0);
        repeat (H - H/2) @(negedge clk);
        scl_m = 1'b0;
    endtask

    // Model update for a write of nbody bytes after the address.
    task automatic model(input logic [6:0] a, input logic rw, input logic [7:0] ins,
                         input logic [7:0] dat, input int nbody);
        if (a == OWN && !rw && nbody >= 1) begin
            exp_sd[ins[6:5]] = ins[3];
            exp_gpo = {ins[2], ins[1]};
            if (ins[4]) exp_code[ins[6:5]] = 8'h80;
            else if (nbody >= 2) exp_code[ins[6:5]] = dat;
        end
    endtask

    // Full transaction: address, then up to three body bytes, then stop.
    task automatic txn(input logic [6:0] a, input logic rw, input logic [7:0] ins,
                       input logic [7:0] dat, input int nbody, output logic [3:0] acks);
        logic ak;
        acks = 4'b0000;
        bus_start();
        send_byte({a, rw}, ak); acks[0] = ak;
        if (nbody >= 1) begin send_byte(ins, ak); acks[1] = ak; end
        if (nbody >= 2) begin send_byte(dat, ak); acks[2] = ak; end
        if (nbody >= 3) begin send_byte(8'hA5, ak); acks[3] = ak; end
        bus_stop();
        repeat (4) @(negedge clk);
        model(a, rw, ins, dat, nbody);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [3:0] acks;
        logic       ak;
        void'($urandom(32'h1C2D));
        for (int c = 0; c < 4; c++) exp_code[c] = 8'h80;
        exp_sd = 4'b0000;
        exp_gpo = 2'b00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R9: reset state
        chk_state("R9 reset");
        chk("R9 sda_oe", {31'd0, sda_oe}, 32'd0);

        // R1 R3 R4 R5: plain write to channel 2, ignored bits 7 and 0 set
        txn(OWN, 1'b0, 8'hC5, 8'h3C, 2, acks);
        chk("R1 R3 ack pattern", {28'd0, acks}, 32'h7);
        chk_state("R4 R5 write ch2");

        // R6: mid-scale command discards data
        txn(OWN, 1'b0, 8'h50, 8'h11, 2, acks);
        chk("R6 acks", {28'd0, acks}, 32'h7);
        chk_state("R6 midscale ch2");

        // R7: shutdown of ch1 keeps its code; then restore
        txn(OWN, 1'b0, 8'h20, 8'h22, 2, acks);
        txn(OWN, 1'b0, 8'h28, 8'h00, 1, acks);
        chk_state("R7 shutdown ch1");
        txn(OWN, 1'b0, 8'h20, 8'h00, 1, acks);
        chk_state("R7 release ch1");

        // R8: global shutdown pin
        shdn_n = 1'b0; repeat (4) @(negedge clk);
        chk_state("R8 pin low");
        chk("R8 all off", {28'd0, chan_off}, 32'hF);
        shdn_n = 1'b1; repeat (4) @(negedge clk);
        chk_state("R8 pin high");

        // R2: wrong address, no acknowledge, no change
        txn(OWN ^ 7'h01, 1'b0, 8'h60, 8'h99, 2, acks);
        chk("R2 no ack", {28'd0, acks}, 32'h0);
        chk_state("R2 unchanged");

        // R11: read request acknowledged only at the address
        txn(OWN, 1'b1, 8'h60, 8'h99, 2, acks);
        chk("R11 acks", {28'd0, acks}, 32'h1);
        chk_state("R11 unchanged");

        // R12: extra byte after data
        txn(OWN, 1'b0, 8'h00, 8'h44, 3, acks);
        chk("R12 acks", {28'd0, acks}, 32'h7);
        chk_state("R12 state");

        // R10: stop in the middle of the data byte
        bus_start();
        send_byte({OWN, 1'b0}, ak);
        send_byte(8'h6E, ak);
        send_bits(8'hF0, 4);
        bus_stop();
        repeat (4) @(negedge clk);
        exp_sd[3] = 1'b1; exp_gpo = 2'b11;
        chk_state("R10 stop mid data");

        // R10: repeated start in the middle of the instruction byte
        bus_start();
        send_byte({OWN, 1'b0}, ak);
        send_bits(8'h1E, 5);
        txn(OWN, 1'b0, 8'h00, 8'h5A, 2, acks);
        chk("R10 restart acks", {28'd0, acks}, 32'h7);
        chk_state("R10 restart");

        // Random traffic with the shutdown pin toggling mid-transaction (R5 R7 R8)
        for (int n = 0; n < 40; n++) begin
            logic [6:0] a;
            logic [7:0] ins;
            logic [7:0] dat;
            int         dly;
            a   = ($urandom_range(0, 3) == 0) ? 7'($urandom) : OWN;
            ins = 8'($urandom);
            dat = 8'($urandom);
            dly = $urandom_range(10, 400);
            fork
                txn(a, 1'b0, ins, dat, 2, acks);
                begin repeat (dly) @(negedge clk); shdn_n = ~shdn_n; end
            join
            chk("R3 random acks", {28'd0, acks}, (a == OWN) ? 32'h7 : 32'h0);
            chk_state("R8 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule